// File: doc/BRIEF.md
# Authenticated Copy Controller

This block sequences one authenticated write from a byte-wide scratchpad into protected memory. When a copy command begins, the master first echoes three authorization bytes. The controller compares them with the target-address and status registers it currently holds. If all three bytes agree and the target area is not write-protected, the controller pulses a start request to an external hash engine. It then waits a fixed compute interval.

After that interval the controller accepts a message authentication code (MAC) from the master, one byte at a time. It compares the MAC with the code the hash engine produced. On a match it drives a copy strobe for a fixed programming interval, and the memory array moves the scratchpad into place during that time.

The outcome is reported in a result byte with three possible values. The hash core, the memory array and the bus physical layer sit outside this block. A bus reset abandons the command from any state.

Top module: `auth_copy_ctrl`

## Requirements
- R1: After reset, `busy`, `hash_start` and `copy_strobe` are low and `result_byte` reads FFh.
- R2: In idle, a `cmd_start` pulse starts a command. From the next cycle `busy` is high and `result_byte` reads FFh until the command concludes.
- R3: Exactly three authorization bytes are taken while `rx_valid` is high. The first is compared with `held_ta1`, the second with `held_ta2` and the third with `held_es`. A correct byte set sent in another order is rejected.
- R4: `hash_start` is a single-cycle pulse in the cycle after the third authorization byte. It occurs only when all three bytes matched and `wr_protect` was low on that byte.
- R5: A wrong authorization byte, or `wr_protect` high on the third byte, returns the block to idle in the next cycle with `result_byte` FFh and no `hash_start`.
- R6: After `hash_start` the block ignores `rx_valid` for exactly T_CSHA cycles. The MAC is accepted only after that.
- R7: The MAC is MAC_BITS (160) bits, sent as MAC_BITS/8 bytes. Received byte k is compared with `local_mac[8k+7:8k]`.
- R8: If every MAC byte matches, `copy_strobe` is high for exactly T_PROG cycles starting the cycle after the last MAC byte. The block then returns to idle with `result_byte` AAh.
- R9: If any MAC byte differs, the block returns to idle in the cycle after the last MAC byte with `result_byte` 00h, and `copy_strobe` never rises.
- R10: A `bus_reset` in any state returns the block to idle in the next cycle with `copy_strobe` low and `result_byte` unchanged.
- R11: While idle, `result_byte` holds its value until the next `cmd_start`.
- R12: `rx_valid` bytes have no effect while idle, and `cmd_start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Bus reset seen by the physical layer; aborts any command |
| cmd_start | input | 1 | One-cycle pulse: authenticated copy command decoded |
| rx_valid | input | 1 | Byte from master valid this cycle |
| rx_byte | input | BYTE_W | Byte from master |
| held_ta1 | input | BYTE_W | Held target address, low byte |
| held_ta2 | input | BYTE_W | Held target address, high byte |
| held_es | input | BYTE_W | Held ending-offset/status byte |
| wr_protect | input | 1 | Target area is write-protected |
| local_mac | input | MAC_BITS | MAC computed by the hash engine |
| busy | output | 1 | Command in progress |
| hash_start | output | 1 | One-cycle start request to the hash engine |
| copy_strobe | output | 1 | Programming window: scratchpad to memory |
| result_byte | output | 8 | AAh success, 00h MAC mismatch, FFh rejected |

## Verification
The checker watches four things on every cycle:
- `hash_start` is never longer than one cycle and always follows a received byte.
- A bus reset always leaves the block idle with no strobe.
- The result byte only ever holds one of its three codes and stays frozen while idle.
- A programming window that ends without a bus reset always leaves AAh.

Other properties can only be shown by the bench's scenarios. These are the exact length of the compute and programming windows, the order in which authorization bytes are matched, and the per-byte MAC comparison including a flip in the last byte. So is the rule that bytes sent early during the compute window are discarded.

// File: rtl/authcopy_pkg.sv
package authcopy_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_AUTH,
      ST_HASH,
      ST_MAC,
      ST_PROG
   } ctl_state_e;

   localparam logic [7:0] RES_OK     = 8'hAA;
   localparam logic [7:0] RES_BADMAC = 8'h00;
   localparam logic [7:0] RES_REJECT = 8'hFF;
endpackage

// File: rtl/acc_auth_match.sv
// Sticky comparator for the echoed authorization bytes.
// Slot g of exp_flat is the value expected at index g.
module acc_auth_match #(
   parameter int BYTE_W  = 8,
   parameter int N_BYTES = 3,
   parameter int IDX_W   = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      valid,
   input  logic [IDX_W-1:0]          idx,
   input  logic [BYTE_W-1:0]         rx,
   input  logic [N_BYTES*BYTE_W-1:0] exp_flat,
   output logic                      err_now
);
   logic [N_BYTES-1:0] slot_miss;
   logic               err_q;

   for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
      assign slot_miss[g] = (idx == IDX_W'(g)) &&
                            (rx != exp_flat[g*BYTE_W +: BYTE_W]);
   end

   assign err_now = err_q | (valid & (|slot_miss));

   always_ff @(posedge clk) begin
      if (!rst_n)     err_q <= 1'b0;
      else if (clr)   err_q <= 1'b0;
      else if (valid) err_q <= err_now;
   end
endmodule

// File: rtl/acc_mac_check.sv
// MAC comparison with two variants.
//   SERIAL=1 keeps a running per-byte mismatch flag.
//   SERIAL=0 gathers every byte and does one wide compare.
// mismatch_now is meaningful on the cycle the last byte is valid.
module acc_mac_check #(
   parameter int BYTE_W   = 8,
   parameter int MAC_BITS = 160,
   parameter int IDX_W    = 5,
   parameter bit SERIAL   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                valid,
   input  logic [IDX_W-1:0]    idx,
   input  logic [BYTE_W-1:0]   rx,
   input  logic [MAC_BITS-1:0] local_mac,
   output logic                mismatch_now
);
   localparam int N_BYTES = MAC_BITS / BYTE_W;

   if (SERIAL) begin : g_serial
      logic [N_BYTES-1:0] slot_miss;
      logic               err_q;

      for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
         assign slot_miss[g] = (idx == IDX_W'(g)) &&
                               (rx != local_mac[g*BYTE_W +: BYTE_W]);
      end

      assign mismatch_now = err_q | (valid & (|slot_miss));

      always_ff @(posedge clk) begin
         if (!rst_n)     err_q <= 1'b0;
         else if (clr)   err_q <= 1'b0;
         else if (valid) err_q <= mismatch_now;
      end
   end else begin : g_gather
      logic [MAC_BITS-1:0] buf_q;
      logic [MAC_BITS-1:0] merged;

      for (genvar g = 0; g < N_BYTES; g++) begin : g_slot
         assign merged[g*BYTE_W +: BYTE_W] =
            (valid && (idx == IDX_W'(g))) ? rx : buf_q[g*BYTE_W +: BYTE_W];
      end

      assign mismatch_now = (merged != local_mac);

      always_ff @(posedge clk) begin
         if (!rst_n)     buf_q <= '0;
         else if (clr)   buf_q <= '0;
         else if (valid) buf_q <= merged;
      end
   end
endmodule

// File: rtl/acc_interval.sv
// Down-counter for a fixed interval.
// expire is high in the last cycle of a loaded interval.
module acc_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   assign expire = (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (abort)          cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end
endmodule

// File: rtl/auth_copy_ctrl.sv
module auth_copy_ctrl
   import authcopy_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int AUTH_BYTES = 3,
   parameter int MAC_BITS   = 160,
   parameter int T_CSHA     = 1500,
   parameter int T_PROG     = 5000,
   parameter bit MAC_SERIAL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_reset,
   input  logic                cmd_start,
   input  logic                rx_valid,
   input  logic [BYTE_W-1:0]   rx_byte,
   input  logic [BYTE_W-1:0]   held_ta1,
   input  logic [BYTE_W-1:0]   held_ta2,
   input  logic [BYTE_W-1:0]   held_es,
   input  logic                wr_protect,
   input  logic [MAC_BITS-1:0] local_mac,
   output logic                busy,
   output logic                hash_start,
   output logic                copy_strobe,
   output logic [7:0]          result_byte
);
   localparam int MAC_BYTES = MAC_BITS / BYTE_W;
   localparam int IDX_W     = $clog2(MAC_BYTES + 1);
   localparam int T_MAX     = (T_CSHA > T_PROG) ? T_CSHA : T_PROG;
   localparam int CNT_W     = $clog2(T_MAX + 1);
   localparam logic [IDX_W-1:0] LAST_AUTH = IDX_W'(AUTH_BYTES - 1);
   localparam logic [IDX_W-1:0] LAST_MAC  = IDX_W'(MAC_BYTES - 1);

   if (BYTE_W < 1)                  begin : g_bad_bw  $error("BYTE_W must be positive"); end
   if (AUTH_BYTES != 3)             begin : g_bad_ab  $error("AUTH_BYTES must be 3"); end
   if ((MAC_BITS % BYTE_W) != 0)    begin : g_bad_mac $error("MAC_BITS must be a multiple of BYTE_W"); end
   if (MAC_BYTES < AUTH_BYTES)      begin : g_bad_mb  $error("MAC shorter than authorization pattern"); end
   if (T_CSHA < 1 || T_PROG < 1)    begin : g_bad_t   $error("intervals must be at least one cycle"); end

   ctl_state_e          st_q, st_d;
   logic [IDX_W-1:0]    idx_q, idx_d;
   logic [7:0]          res_q, res_d;
   logic                hs_q, hs_d;
   logic                auth_clr, mac_clr;
   logic                tmr_load, tmr_abort, tmr_expire;
   logic [CNT_W-1:0]    tmr_val;
   logic                auth_err_now, mac_err_now;
   logic                auth_valid, mac_valid;

   assign auth_valid = rx_valid && (st_q == ST_AUTH);
   assign mac_valid  = rx_valid && (st_q == ST_MAC);

   acc_auth_match #(
      .BYTE_W  (BYTE_W),
      .N_BYTES (AUTH_BYTES),
      .IDX_W   (IDX_W)
   ) u_auth (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (auth_clr),
      .valid    (auth_valid),
      .idx      (idx_q),
      .rx       (rx_byte),
      .exp_flat ({held_es, held_ta2, held_ta1}),
      .err_now  (auth_err_now)
   );

   acc_mac_check #(
      .BYTE_W   (BYTE_W),
      .MAC_BITS (MAC_BITS),
      .IDX_W    (IDX_W),
      .SERIAL   (MAC_SERIAL)
   ) u_mac (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr          (mac_clr),
      .valid        (mac_valid),
      .idx          (idx_q),
      .rx           (rx_byte),
      .local_mac    (local_mac),
      .mismatch_now (mac_err_now)
   );

   acc_interval #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort    (tmr_abort),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_expire)
   );

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      res_d     = res_q;
      hs_d      = 1'b0;
      auth_clr  = 1'b0;
      mac_clr   = 1'b0;
      tmr_load  = 1'b0;
      tmr_abort = 1'b0;
      tmr_val   = '0;
      if (bus_reset) begin
         st_d      = ST_IDLE;
         idx_d     = '0;
         tmr_abort = 1'b1;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_start) begin
                  st_d     = ST_AUTH;
                  idx_d    = '0;
                  res_d    = RES_REJECT;
                  auth_clr = 1'b1;
               end
            end
            ST_AUTH: begin
               if (rx_valid) begin
                  if (idx_q == LAST_AUTH) begin
                     idx_d = '0;
                     if (auth_err_now || wr_protect) begin
                        st_d = ST_IDLE;
                     end else begin
                        st_d     = ST_HASH;
                        hs_d     = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_CSHA);
                        mac_clr  = 1'b1;
                     end
                  end else begin
                     idx_d = idx_q + IDX_W'(1);
                  end
               end
            end
            ST_HASH: begin
               if (tmr_expire) st_d = ST_MAC;
            end
            ST_MAC: begin
               if (rx_valid) begin
                  if (idx_q == LAST_MAC) begin
                     idx_d = '0;
                     if (mac_err_now) begin
                        st_d  = ST_IDLE;
                        res_d = RES_BADMAC;
                     end else begin
                        st_d     = ST_PROG;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(T_PROG);
                     end
                  end else begin
                     idx_d = idx_q + IDX_W'(1);
                  end
               end
            end
            ST_PROG: begin
               if (tmr_expire) begin
                  st_d  = ST_IDLE;
                  res_d = RES_OK;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         res_q <= RES_REJECT;
         hs_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         res_q <= res_d;
         hs_q  <= hs_d;
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign hash_start  = hs_q;
   assign copy_strobe = (st_q == ST_PROG);
   assign result_byte = res_q;
endmodule

// File: rtl/acc_ctl_chk.sv
module acc_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_reset,
   input logic       cmd_start,
   input logic       rx_valid,
   input logic       busy,
   input logic       hash_start,
   input logic       copy_strobe,
   input logic [7:0] result_byte
);
   // R4
   hash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hash_start |=> !hash_start);

   // R4
   hash_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hash_start |-> ($past(rx_valid) && !$past(bus_reset)));

   // R10
   bus_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (!busy && !copy_strobe && !hash_start));

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_start) |=> $stable(result_byte));

   // R1
   result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (result_byte == 8'hAA) || (result_byte == 8'h00) || (result_byte == 8'hFF));

   // R8
   prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(copy_strobe) && !$past(bus_reset)) |-> (result_byte == 8'hAA));

   // R2
   strobe_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_strobe |-> (busy && result_byte == 8'hFF));
endmodule

bind auth_copy_ctrl acc_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_reset   (bus_reset),
   .cmd_start   (cmd_start),
   .rx_valid    (rx_valid),
   .busy        (busy),
   .hash_start  (hash_start),
   .copy_strobe (copy_strobe),
   .result_byte (result_byte)
);

// File: tb/tb_auth_copy_ctrl.sv
module tb_auth_copy_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int T_CSHA_TB  = 12;
   localparam int T_PROG_TB  = 9;
   localparam int MACB       = 160;
   localparam int NMB        = MACB / 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_reset = 1'b0;
   logic            cmd_start = 1'b0;
   logic            rx_valid = 1'b0;
   logic [7:0]      rx_byte = '0;
   logic [7:0]      ta1 = '0, ta2 = '0, es = '0;
   logic            wr_protect = 1'b0;
   logic [MACB-1:0] lmac = '0;
   logic            busy, hash_start, copy_strobe;
   logic [7:0]      result_byte;

   int n_chk = 0;
   int n_bad = 0;
   int hs_cnt = 0;
   int cs_cnt = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   auth_copy_ctrl #(
      .BYTE_W (8), .AUTH_BYTES (3), .MAC_BITS (MACB),
      .T_CSHA (T_CSHA_TB), .T_PROG (T_PROG_TB), .MAC_SERIAL (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .bus_reset (bus_reset), .cmd_start (cmd_start),
      .rx_valid (rx_valid), .rx_byte (rx_byte), .held_ta1 (ta1), .held_ta2 (ta2),
      .held_es (es), .wr_protect (wr_protect), .local_mac (lmac), .busy (busy),
      .hash_start (hash_start), .copy_strobe (copy_strobe), .result_byte (result_byte)
   );

   always @(negedge clk) begin
      if (rst_n && hash_start)  hs_cnt++;
      if (rst_n && copy_strobe) cs_cnt++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_result(input bit auth_ok, input bit prot, input bit mac_ok);
      if (!auth_ok || prot) return 8'hFF;
      if (!mac_ok)          return 8'h00;
      return 8'hAA;
   endfunction

   task automatic idle_cycles(input int n);
      rx_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b, input int max_gap);
      idle_cycles((max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   function automatic logic [7:0] nz_flip();
      return 8'(1 + ($urandom % 255));
   endfunction

   // abort_at: 0 none, 1 during compute window, 2 during programming window
   task automatic run_cmd(input int auth_err, input bit prot, input int mac_err,
                          input bit swap, input bit mid_start, input int abort_at);
      logic [7:0] a [3];
      logic [7:0] exp_r;
      bit auth_ok, mac_ok;
      int hs0, cs0;
      ta1 = 8'($urandom);
      ta2 = ta1 ^ nz_flip();
      es  = 8'($urandom);
      for (int k = 0; k < NMB; k++) lmac[k*8 +: 8] = 8'($urandom);
      wr_protect = prot;
      a[0] = ta1; a[1] = ta2; a[2] = es;
      if (swap) begin a[0] = ta2; a[1] = ta1; end
      if (auth_err >= 0) a[auth_err] = a[auth_err] ^ nz_flip();
      auth_ok = (auth_err < 0) && !swap;
      mac_ok  = (mac_err < 0);
      exp_r   = exp_result(auth_ok, prot, mac_ok);
      hs0 = hs_cnt; cs0 = cs_cnt;

      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(result_byte == 8'hFF, "R2 result during command", result_byte, 8'hFF);

      for (int i = 0; i < 3; i++) begin
         send_byte(a[i], 2);
         if (mid_start && i == 0) begin
            cmd_start = 1'b1;         // R12: ignored while busy
            @(negedge clk);
            cmd_start = 1'b0;
         end
      end

      if (!auth_ok || prot) begin
         check(busy == 1'b0, "R5 idle after rejected pattern", busy, 0);
         check(result_byte == exp_r, "R5 R3 reject code", result_byte, exp_r);
         check(hs_cnt == hs0, "R4 no hash start", hs_cnt - hs0, 0);
         idle_cycles(T_CSHA_TB + 4);
         check(cs_cnt == cs0 && !busy, "R5 no copy after reject", cs_cnt - cs0, 0);
         return;
      end

      check(hash_start == 1'b1, "R4 hash start pulse", hash_start, 1);
      for (int i = 0; i < T_CSHA_TB; i++) begin
         rx_valid = 1'($urandom % 2);           // R6: early bytes discarded
         rx_byte  = 8'($urandom);
         @(negedge clk);
         if (abort_at == 1 && i == 3) begin
            rx_valid  = 1'b0;
            bus_reset = 1'b1;
            @(negedge clk);
            bus_reset = 1'b0;
            check(busy == 1'b0, "R10 abort in compute", busy, 0);
            check(result_byte == 8'hFF, "R10 result kept", result_byte, 8'hFF);
            for (int k = 0; k < NMB; k++) send_byte(lmac[k*8 +: 8], 0);
            check(!busy && cs_cnt == cs0, "R12 bytes ignored in idle", cs_cnt - cs0, 0);
            check(result_byte == 8'hFF, "R12 result untouched", result_byte, 8'hFF);
            return;
         end
      end
      rx_valid = 1'b0;

      for (int k = 0; k < NMB; k++) begin
         logic [7:0] b;
         b = lmac[k*8 +: 8];
         if (k == mac_err) b = b ^ nz_flip();
         send_byte(b, 1);
      end

      if (!mac_ok) begin
         check(busy == 1'b0, "R9 idle after bad MAC", busy, 0);
         check(result_byte == exp_r, "R9 R7 mismatch code", result_byte, exp_r);
         check(cs_cnt == cs0, "R9 no copy strobe", cs_cnt - cs0, 0);
      end else begin
         check(copy_strobe == 1'b1, "R8 R7 strobe after MAC", copy_strobe, 1);
         if (abort_at == 2) begin
            idle_cycles(2);
            bus_reset = 1'b1;
            @(negedge clk);
            bus_reset = 1'b0;
            check(!busy && !copy_strobe, "R10 abort in programming", copy_strobe, 0);
            check(result_byte == 8'hFF, "R10 result unchanged", result_byte, 8'hFF);
            idle_cycles(T_PROG_TB);
            check(cs_cnt - cs0 == 3, "R10 strobe cut short", cs_cnt - cs0, 3);
            return;
         end
         idle_cycles(T_PROG_TB);
         check(busy == 1'b0, "R8 idle after programming", busy, 0);
         check(result_byte == exp_r, "R8 success code", result_byte, exp_r);
         check(cs_cnt - cs0 == T_PROG_TB, "R8 strobe length", cs_cnt - cs0, T_PROG_TB);
         check(hs_cnt - hs0 == 1, "R4 one hash start", hs_cnt - hs0, 1);
      end

      exp_r = result_byte;
      for (int i = 0; i < 6; i++) begin
         rx_valid = 1'($urandom % 2);
         rx_byte  = 8'($urandom);
         @(negedge clk);
      end
      rx_valid = 1'b0;
      check(result_byte == exp_r && !busy, "R11 R12 result held in idle", result_byte, exp_r);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      idle_cycles(4);
      check(busy == 1'b0 && hash_start == 1'b0 && copy_strobe == 1'b0,
            "R1 reset outputs", {busy, hash_start, copy_strobe}, 0);
      check(result_byte == 8'hFF, "R1 reset result", result_byte, 8'hFF);
      rst_n = 1'b1;
      idle_cycles(2);
      check(result_byte == 8'hFF && !busy, "R1 after release", result_byte, 8'hFF);

      run_cmd(-1, 1'b0, -1, 1'b0, 1'b0, 0);             // R8 clean success
      run_cmd(-1, 1'b0, NMB - 1, 1'b0, 1'b0, 0);        // R7 last byte wrong
      run_cmd(-1, 1'b0, 0, 1'b0, 1'b0, 0);              // R9 first byte wrong
      run_cmd(-1, 1'b0, -1, 1'b1, 1'b0, 0);             // R3 order swapped
      run_cmd(2, 1'b0, -1, 1'b0, 1'b0, 0);              // R3 status byte wrong
      run_cmd(-1, 1'b1, -1, 1'b0, 1'b0, 0);             // R5 protected
      run_cmd(-1, 1'b0, -1, 1'b0, 1'b1, 0);             // R12 start while busy
      run_cmd(-1, 1'b0, -1, 1'b0, 1'b0, 1);             // R10 abort in compute
      run_cmd(-1, 1'b0, -1, 1'b0, 1'b0, 2);             // R10 abort in programming
      run_cmd(-1, 1'b0, -1, 1'b0, 1'b0, 0);             // R11 recovers

      for (int n = 0; n < 60; n++) begin
         int ae, me;
         ae = ($urandom % 4 == 0) ? int'($urandom % 3) : -1;
         me = ($urandom % 3 == 0) ? int'($urandom % NMB) : -1;
         run_cmd(ae, 1'($urandom % 6 == 0), me, 1'($urandom % 10 == 0),
                 1'($urandom % 8 == 0), 0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule